// File: doc/BRIEF.md
# Rotating-Frame Flux Hysteresis Vector Selector

This block is the switching decision stage of a carrier-less flux regulator for a two-level, three-phase inverter. On every clock it reads two signed flux error components that an upstream stage has already rotated into the synchronous frame: a radial (d-axis) error and a tangential (q-axis) error. It compares them against two independently programmed band limits, which together form a rectangular error box. The result is the 3-bit leg state to apply, one bit per phase.

Radial band violations move the inverter one active vector forward or back around the hexagon, depending on whether the flux lags or leads. A tangential overshoot parks the inverter on the zero vector that is one leg transition away. A tangential undershoot during a zero interval brings back the active vector that was in use before that interval. A programmable minimum dwell, counted in clock cycles, keeps every state applied for at least that many cycles. A change requested earlier is deferred until the dwell has elapsed. A one-cycle strobe marks every change of leg state.

Top module: `flux_vec_select`

## Requirements
- R1: Reset (synchronous, active high) drives leg_state to 000 and leg_change to 0, and sets the stored active vector to 100. The first restore after reset therefore yields 100.
- R2: While an active vector is applied, if rad_err > rad_band and tan_err < 0 (lagging), the next state is one place forward in the active ring 100 → 110 → 010 → 011 → 001 → 101 → 100. Bit 2 is the first leg, and the ring wraps.
- R3: While an active vector is applied, if rad_err < −rad_band and tan_err > 0 (leading), the next state is one place back in the same ring, with wrap-around.
- R4: While an active vector is applied and neither radial rule fires, tan_err > tan_band selects a zero vector. The result is 111 when the active vector has two legs high, and 000 when it has one leg high.
- R5: While a zero vector (000 or 111) is applied, tan_err < −tan_band restores the last active vector that was applied.
- R6: While a zero vector is applied, radial errors have no effect on leg_state.
- R7: A new state is applied at an edge only when the present state has already been held for at least min_hold cycles (0 acts as 1). A request that comes earlier is taken at the first permitted edge at which it is still present.
- R8: leg_change is high for exactly the one cycle in which a new leg_state value first appears, and low otherwise.
- R9: All band comparisons are strict: an error equal to a band limit, or to its negative, requests no change.
- R10: When a radial rule and the tangential zero rule fire together, the radial rule wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rad_err | input | ERR_W | Signed radial flux error |
| tan_err | input | ERR_W | Signed tangential flux error (negative = lagging) |
| rad_band | input | ERR_W-1 | Radial band half-width, unsigned |
| tan_band | input | ERR_W-1 | Tangential band half-width, unsigned |
| min_hold | input | CNT_W | Minimum cycles any state is held |
| leg_state | output | 3 | Applied leg state, bit 2 first leg |
| leg_change | output | 1 | One-cycle strobe on each change of leg_state |

## Verification
The inputs are sampled at a rising edge. Any resulting change of leg_state, and its leg_change strobe, is visible immediately after that same edge, with no extra pipeline delay. The bench drives inputs at the falling edge. At the next falling edge it compares both outputs against a behavioural model that was advanced with the same inputs. Each comparison therefore sees exactly the edge at which the stimulus was sampled. The dwell window of R7 is measured by the model counting edges since its own last change, so deferred requests land on the predicted edge.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef logic [2:0] leg_t;

    localparam leg_t LEG_ZERO_LO = 3'b000;
    localparam leg_t LEG_ZERO_HI = 3'b111;
    localparam leg_t LEG_FIRST   = 3'b100;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_STEP_FWD,
        ACT_STEP_BACK,
        ACT_TO_ZERO,
        ACT_RESTORE
    } act_e;

    typedef struct packed {
        act_e act;
        leg_t target;
    } decision_t;

    function automatic logic is_zero(input leg_t v);
        return (v == LEG_ZERO_LO) || (v == LEG_ZERO_HI);
    endfunction

    // one step forward (+60 degrees) around the active hexagon
    function automatic leg_t ring_fwd(input leg_t v);
        case (v)
            3'b100:  return 3'b110;
            3'b110:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b001;
            3'b001:  return 3'b101;
            3'b101:  return 3'b100;
            default: return LEG_FIRST;
        endcase
    endfunction

    // one step back (-60 degrees) around the active hexagon
    function automatic leg_t ring_back(input leg_t v);
        case (v)
            3'b100:  return 3'b101;
            3'b101:  return 3'b001;
            3'b001:  return 3'b011;
            3'b011:  return 3'b010;
            3'b010:  return 3'b110;
            3'b110:  return 3'b100;
            default: return LEG_FIRST;
        endcase
    endfunction

    // zero vector reachable with a single leg transition
    function automatic leg_t near_zero(input leg_t v);
        return ($countones(v) == 2) ? LEG_ZERO_HI : LEG_ZERO_LO;
    endfunction

endpackage

// File: rtl/vsel_rule_engine.sv
module vsel_rule_engine
    import vsel_pkg::*;
#(
    parameter int ERR_W = 16
) (
    input  leg_t                    cur_leg,
    input  leg_t                    last_act,
    input  logic signed [ERR_W-1:0] rad_err,
    input  logic signed [ERR_W-1:0] tan_err,
    input  logic [ERR_W-2:0]        rad_band,
    input  logic [ERR_W-2:0]        tan_band,
    output decision_t               dec
);
    localparam int XW = ERR_W + 1;

    logic signed [XW-1:0] re, te, rb, tb;
    logic lagging_out, leading_in, tan_over, tan_under;

    assign re = {rad_err[ERR_W-1], rad_err};
    assign te = {tan_err[ERR_W-1], tan_err};
    assign rb = $signed({2'b00, rad_band});
    assign tb = $signed({2'b00, tan_band});

    assign lagging_out = (re > rb)  && (te < 0);
    assign leading_in  = (re < -rb) && (te > 0);
    assign tan_over    = (te > tb);
    assign tan_under   = (te < -tb);

    always_comb begin
        dec.act    = ACT_HOLD;
        dec.target = cur_leg;
        if (!is_zero(cur_leg)) begin
            if (lagging_out) begin
                dec.act    = ACT_STEP_FWD;
                dec.target = ring_fwd(cur_leg);
            end else if (leading_in) begin
                dec.act    = ACT_STEP_BACK;
                dec.target = ring_back(cur_leg);
            end else if (tan_over) begin
                dec.act    = ACT_TO_ZERO;
                dec.target = near_zero(cur_leg);
            end
        end else if (tan_under) begin
            dec.act    = ACT_RESTORE;
            dec.target = last_act;
        end
    end

    // R10: with both radial-lead and tangential-over present, a radial step is chosen
    always_comb begin
        if (!is_zero(cur_leg) && leading_in && tan_over)
            a_radial_first_r10: assert (dec.act == ACT_STEP_BACK);
    end

endmodule

// File: rtl/vsel_hold_timer.sv
module vsel_hold_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] min_hold,
    output logic             ready
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst || restart)
            held <= CNT_ONE;
        else if (held != CNT_MAX)
            held <= held + CNT_ONE;
    end

    assign ready = (held >= min_hold);

    // R7: counter never drops below one cycle of dwell
    p_held_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        held != '0);

endmodule

// File: rtl/flux_vec_select.sv
module flux_vec_select
    import vsel_pkg::*;
#(
    parameter int ERR_W = 16,
    parameter int CNT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ERR_W-1:0] rad_err,
    input  logic signed [ERR_W-1:0] tan_err,
    input  logic [ERR_W-2:0]        rad_band,
    input  logic [ERR_W-2:0]        tan_band,
    input  logic [CNT_W-1:0]        min_hold,
    output logic [2:0]              leg_state,
    output logic                    leg_change
);
    leg_t      leg_q, last_act_q;
    logic      strobe_q;
    decision_t dec;
    logic      ready, go;

    vsel_rule_engine #(.ERR_W(ERR_W)) u_rules (
        .cur_leg  (leg_q),
        .last_act (last_act_q),
        .rad_err  (rad_err),
        .tan_err  (tan_err),
        .rad_band (rad_band),
        .tan_band (tan_band),
        .dec      (dec)
    );

    vsel_hold_timer #(.CNT_W(CNT_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .restart  (go),
        .min_hold (min_hold),
        .ready    (ready)
    );

    assign go = (dec.act != ACT_HOLD) && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            leg_q      <= LEG_ZERO_LO;
            last_act_q <= LEG_FIRST;
            strobe_q   <= 1'b0;
        end else begin
            strobe_q <= go;
            if (go) begin
                leg_q <= dec.target;
                if (!is_zero(dec.target))
                    last_act_q <= dec.target;
            end
        end
    end

    assign leg_state  = leg_q;
    assign leg_change = strobe_q;

    // R8: strobe exactly when the leg state moved
    p_strobe_on_change_r8: assert property (@(posedge clk) disable iff (rst)
        leg_change == (leg_q != $past(leg_q)));

    // R7: a move happens only when the dwell timer allowed it
    p_move_after_dwell_r7: assert property (@(posedge clk) disable iff (rst)
        (leg_q != $past(leg_q)) |-> $past(ready));

    // R2/R3: active-to-active moves are adjacent (one leg flips)
    p_adjacent_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!is_zero($past(leg_q)) && !is_zero(leg_q) && leg_q != $past(leg_q))
            |-> ($countones(leg_q ^ $past(leg_q)) == 1));

    // R4: entering a zero vector flips exactly one leg
    p_zero_one_leg_r4: assert property (@(posedge clk) disable iff (rst)
        (!is_zero($past(leg_q)) && is_zero(leg_q))
            |-> ($countones(leg_q ^ $past(leg_q)) == 1));

    // R5/R6: leaving a zero vector always lands on the stored active vector
    p_restore_last_r5: assert property (@(posedge clk) disable iff (rst)
        (is_zero($past(leg_q)) && leg_q != $past(leg_q))
            |-> (leg_q == $past(last_act_q)));

endmodule

// File: tb/test_flux_vec_select.sv
module test_flux_vec_select;

    localparam int ERR_W = 16;
    localparam int CNT_W = 12;
    localparam int CNT_SAT = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [ERR_W-1:0] rad_err = '0, tan_err = '0;
    logic [ERR_W-2:0] rad_band = '0, tan_band = '0;
    logic [CNT_W-1:0] min_hold = '0;
    logic [2:0] leg_state;
    logic leg_change;

    always #10 clk = ~clk;

    flux_vec_select #(.ERR_W(ERR_W), .CNT_W(CNT_W)) i_flux_vec_select (
        .clk(clk), .rst(rst), .rad_err(rad_err), .tan_err(tan_err),
        .rad_band(rad_band), .tan_band(tan_band), .min_hold(min_hold),
        .leg_state(leg_state), .leg_change(leg_change)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_leg, m_last, m_cnt, m_strobe;
    int hexring[6] = '{4, 6, 2, 3, 1, 5};
    string tag = "R1";

    function automatic int ring_pos(int v);
        for (int i = 0; i < 6; i++) if (hexring[i] == v) return i;
        return 0;
    endfunction

    task automatic model_advance();
        int rd, td, rb, tb, mh, tgt;
        bit req, zero;
        rd = int'(rad_err); td = int'(tan_err);
        rb = int'(rad_band); tb = int'(tan_band); mh = int'(min_hold);
        zero = (m_leg == 0) || (m_leg == 7);
        req = 0; tgt = m_leg;
        if (!zero) begin
            if (rd > rb && td < 0) begin
                req = 1; tgt = hexring[(ring_pos(m_leg) + 1) % 6];
            end else if (rd < -rb && td > 0) begin
                req = 1; tgt = hexring[(ring_pos(m_leg) + 5) % 6];
            end else if (td > tb) begin
                req = 1; tgt = ($countones(m_leg[2:0]) == 2) ? 7 : 0;
            end
        end else if (td < -tb) begin
            req = 1; tgt = m_last;
        end
        if (rst) begin
            m_leg = 0; m_last = 4; m_cnt = 1; m_strobe = 0;
        end else if (req && m_cnt >= mh) begin
            m_leg = tgt;
            if (tgt != 0 && tgt != 7) m_last = tgt;
            m_cnt = 1; m_strobe = 1;
        end else begin
            m_strobe = 0;
            if (m_cnt < CNT_SAT) m_cnt++;
        end
    endtask

    task automatic compare_model();
        n_checks++;
        if (int'(leg_state) != m_leg) begin
            n_fail++;
            $display("FAIL %s leg_state actual=%03b expected=%03b", tag, leg_state, m_leg[2:0]);
        end
        n_checks++;
        if (int'(leg_change) != m_strobe) begin
            n_fail++;
            $display("FAIL R8 (%s) leg_change actual=%0d expected=%0d", tag, leg_change, m_strobe);
        end
    endtask

    task automatic expect_leg(input logic [2:0] exp, input string req);
        n_checks++;
        if (leg_state !== exp) begin
            n_fail++;
            $display("FAIL %s directed leg_state actual=%03b expected=%03b", req, leg_state, exp);
        end
    endtask

    // one clock: set inputs at falling edge, advance model, compare at next falling edge
    task automatic step(input int rd, input int td, input string t);
        tag = t;
        rad_err = ERR_W'(rd);
        tan_err = ERR_W'(td);
        model_advance();
        @(negedge clk);
        compare_model();
    endtask

    task automatic run(input int rd, input int td, input int n, input string t);
        for (int i = 0; i < n; i++) step(rd, td, t);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rad_band = 100; tan_band = 100; min_hold = 1;
        @(negedge clk);
        run(0, 0, 3, "R1");
        rst = 1'b0;
        expect_leg(3'b000, "R1");
        // restore from reset zero gives the initial stored active vector
        run(0, -150, 1, "R1");
        expect_leg(3'b100, "R1");
        run(150, -10, 1, "R2");
        expect_leg(3'b110, "R2");
        run(0, 150, 1, "R4");
        expect_leg(3'b111, "R4");
        run(150, -10, 5, "R6");
        run(-150, 10, 5, "R6");
        expect_leg(3'b111, "R6");
        run(0, -150, 1, "R5");
        expect_leg(3'b110, "R5");
        run(-150, 10, 1, "R3");
        expect_leg(3'b100, "R3");
        run(0, 150, 1, "R4");
        expect_leg(3'b000, "R4");
        run(0, -150, 1, "R5");
        expect_leg(3'b100, "R5");
        // full ring traversals with wrap
        run(150, -10, 8, "R2");
        run(-150, 10, 8, "R3");
        // equality on every limit: no change
        run(100, -100, 4, "R9");
        run(-100, 100, 4, "R9");
        run(100, -5, 3, "R9");
        // radial lead and tangential over together
        run(-150, 150, 3, "R10");
        // dwell: steps spaced by min_hold, deferred requests
        min_hold = 20;
        run(150, -10, 70, "R7");
        run(0, 150, 5, "R7");
        run(0, -150, 30, "R7");
        min_hold = 0;
        run(150, -10, 6, "R7");
        min_hold = 1;
        // randomized sweep across all rules
        for (int blk = 0; blk < 200; blk++) begin
            rad_band = ERR_W'($urandom_range(20, 120));
            tan_band = ERR_W'($urandom_range(20, 120));
            min_hold = CNT_W'($urandom_range(0, 6));
            for (int k = 0; k < 10; k++)
                step($urandom_range(0, 400) - 200, $urandom_range(0, 400) - 200, "R2");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule